// File: doc/BRIEF.md
# Load Byte-Lane Alignment and Merge Unit

This unit stands between a 32-bit word-wide data memory and the register write-back path of a processor. A load request carries a base register value, a 16-bit signed displacement, the load opcode and the current contents of the destination register. The unit forms the effective address and issues a word read at that address with its two lowest bits cleared. One cycle later, when the memory returns the word, the unit produces the value to write back.

Five kinds of load are supported. Byte and halfword loads are signed or unsigned. Full-word loads include the load-linked form, which is treated as an ordinary word load with no reservation. The left and right partial-word loads shift the fetched word by the byte offset and keep a masked part of the old destination value. Byte lanes are numbered big-endian, so byte offset 0 is the most significant byte of the word. Opcodes outside the supported set cause neither a memory read nor a write-back.

Top module: `load_align_unit`

## Requirements
- R1: The effective address is `req_base` plus the 16-bit `req_offset` sign-extended to 32 bits. In the cycle the request is presented, `mem_addr` equals the effective address with bits 1:0 forced to zero, and `mem_rd_en` is high.
- R2: Every accepted request gives exactly one result. `wb_valid` is high for one cycle, in the cycle after the request, and `wb_data` in that cycle is formed from `mem_rdata` of that same cycle. Back-to-back requests give back-to-back results.
- R3: Byte lanes are big-endian. Effective-address bits 1:0 = 0, 1, 2, 3 select word bits 31:24, 23:16, 15:8, 7:0.
- R4: Opcode 32 (signed byte) sign-extends the selected byte to 32 bits. Opcode 36 (unsigned byte) zero-extends it.
- R5: Opcode 33 (signed halfword) sign-extends the selected halfword. Opcode 37 (unsigned halfword) zero-extends it. The halfword is word bits 31:16 when effective-address bit 1 is 0 and bits 15:0 when it is 1. Bit 0 is ignored.
- R6: Opcodes 35 (word) and 48 (load-linked) return the fetched word unchanged, whatever effective-address bits 1:0 are.
- R7: Opcode 34 (left partial) with byte offset k returns the word shifted left by 8k bits. Its low 8k bits come from the old destination value, so offset 0 gives the whole word.
- R8: Opcode 38 (right partial) with byte offset 0 returns the old destination value unchanged. With k = 1, 2, 3 it returns the word shifted right by 32-8k bits, and its upper 32-8k bits come from the old destination value.
- R9: A request with any other opcode drives `mem_rd_en` low and produces no `wb_valid`.
- R10: While `rst_n` is low, and in the first cycle after it rises, `wb_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Load request present this cycle |
| req_op | input | 6 | Load opcode |
| req_base | input | 32 | Base register value |
| req_offset | input | 16 | Signed displacement |
| req_old | input | 32 | Current destination register value |
| mem_rd_en | output | 1 | Word read strobe to memory |
| mem_addr | output | 32 | Word-aligned read address |
| mem_rdata | input | 32 | Word returned by memory one cycle after the read |
| wb_valid | output | 1 | Write-back value valid |
| wb_data | output | 32 | Value to write to the destination register |

## Verification
The hardest cases to reach from the ports are the partial-word merges. For these, the old destination value and the fetched word have to differ in every byte, or a wrong shift or mask goes unseen. The stimulus therefore fills memory with words whose bytes are all distinct and carry mixed sign bits. It pairs each one with an old value of a contrasting pattern, and reaches every byte offset through negative and positive displacements from unaligned bases. The requests are issued back-to-back, so each result must come from its own request's captured opcode, offset and old value, not from a neighbour's.

// File: rtl/ldu_pkg.sv
// Package: shared opcode encodings and decode helpers for the load unit.
// Assumes a 6-bit primary opcode field supplied by the instruction decoder.
package ldu_pkg;

    typedef enum logic [5:0] {
        LD_BYTE_S = 6'd32,
        LD_HALF_S = 6'd33,
        LD_LEFT   = 6'd34,
        LD_WORD   = 6'd35,
        LD_BYTE_U = 6'd36,
        LD_HALF_U = 6'd37,
        LD_RIGHT  = 6'd38,
        LD_LINKED = 6'd48
    } ld_op_e;

    // True for every opcode this unit services.
    function automatic logic op_known(input logic [5:0] op);
        case (op)
            LD_BYTE_S, LD_HALF_S, LD_LEFT, LD_WORD,
            LD_BYTE_U, LD_HALF_U, LD_RIGHT, LD_LINKED: op_known = 1'b1;
            default:                                   op_known = 1'b0;
        endcase
    endfunction

    // True for the two partial-word merge loads.
    function automatic logic op_partial(input logic [5:0] op);
        op_partial = (op == LD_LEFT) || (op == LD_RIGHT);
    endfunction

endpackage

// File: rtl/ldu_addr_gen.sv
// Effective-address generator: base plus sign-extended displacement,
// split into a word-aligned read address and a byte-lane index.
// Assumes no fault checking; any lane offset is accepted.
module ldu_addr_gen #(
    parameter int ADDR_W    = 32,
    parameter int OFFS_W    = 16,
    parameter int LANE_BITS = 2
) (
    input  logic [ADDR_W-1:0]    base,
    input  logic [OFFS_W-1:0]    offset,
    output logic [ADDR_W-1:0]    word_addr,
    output logic [LANE_BITS-1:0] lane
);

    logic [ADDR_W-1:0] off_ext;
    logic [ADDR_W-1:0] eff_addr;

    // Sign-extend the displacement and add it to the base.
    always_comb begin
        off_ext   = {{(ADDR_W-OFFS_W){offset[OFFS_W-1]}}, offset};
        eff_addr  = base + off_ext;
        word_addr = {eff_addr[ADDR_W-1:LANE_BITS], {LANE_BITS{1'b0}}};
        lane      = eff_addr[LANE_BITS-1:0];
    end

endmodule

// File: rtl/ldu_lane_extract.sv
// Lane extractor: picks a byte, halfword or whole word out of the fetched
// word (big-endian lane numbering) and sign- or zero-extends it.
// Assumes the halfword choice ignores the lowest lane bit.
module ldu_lane_extract
    import ldu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0]               word,
    input  logic [$clog2(DATA_W/8)-1:0]     lane,
    input  logic [5:0]                      op,
    output logic [DATA_W-1:0]               result
);

    localparam int LANES     = DATA_W / 8;
    localparam int LANE_BITS = $clog2(LANES);
    localparam int HALF_W    = DATA_W / 2;

    logic [7:0]        byte_at [LANES];
    logic [7:0]        byte_sel;
    logic [HALF_W-1:0] half_sel;

    // Lane g holds the g-th most significant byte of the word.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign byte_at[g] = word[DATA_W-1-8*g -: 8];
    end

    // Select the addressed byte and halfword.
    always_comb begin
        byte_sel = byte_at[lane];
        half_sel = lane[LANE_BITS-1] ? word[HALF_W-1:0] : word[DATA_W-1 -: HALF_W];
    end

    // Extend according to the load kind.
    always_comb begin
        case (op)
            LD_BYTE_S: result = {{(DATA_W-8){byte_sel[7]}}, byte_sel};
            LD_BYTE_U: result = {{(DATA_W-8){1'b0}}, byte_sel};
            LD_HALF_S: result = {{(DATA_W-HALF_W){half_sel[HALF_W-1]}}, half_sel};
            LD_HALF_U: result = {{(DATA_W-HALF_W){1'b0}}, half_sel};
            default:   result = word;
        endcase
    end

endmodule

// File: rtl/ldu_partial_merge.sv
// Partial-word merger: shifts the fetched word by the lane offset and keeps
// the complementary bits of the old destination value.
// Assumes DATA_W is a power-of-two multiple of 8.
module ldu_partial_merge #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0]           word,
    input  logic [DATA_W-1:0]           old,
    input  logic [$clog2(DATA_W/8)-1:0] lane,
    input  logic                        left,
    output logic [DATA_W-1:0]           result
);

    localparam int SH_W = $clog2(DATA_W) + 1;

    logic [SH_W-1:0]   sh_lane;
    logic [SH_W-1:0]   sh_rest;
    logic [DATA_W-1:0] ones;
    logic [DATA_W-1:0] left_val;
    logic [DATA_W-1:0] right_val;

    // Shift amounts: 8 bits per lane, and the remainder of the word.
    always_comb begin
        sh_lane = SH_W'(lane) << 3;
        sh_rest = SH_W'(DATA_W) - sh_lane;
        ones    = '1;
    end

    // Left form: word moves up, old value fills the vacated low bits.
    always_comb begin
        left_val = (word << sh_lane) | (old & ~(ones << sh_lane));
    end

    // Right form: word moves down, old value keeps the upper bits.
    always_comb begin
        if (lane == '0) right_val = old;
        else            right_val = (word >> sh_rest) | (old & (ones << sh_lane));
    end

    // Choose the merge direction.
    always_comb begin
        result = left ? left_val : right_val;
    end

endmodule

// File: rtl/load_align_unit.sv
// Load alignment unit: issues a word read for a load request and, one cycle
// later, forms the write-back value from the returned word.
// Assumes a synchronous memory that returns data the cycle after the read.
module load_align_unit
    import ldu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int OFFS_W = 16,
    parameter int OP_W   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [OP_W-1:0]   req_op,
    input  logic [DATA_W-1:0] req_base,
    input  logic [OFFS_W-1:0] req_offset,
    input  logic [DATA_W-1:0] req_old,
    output logic              mem_rd_en,
    output logic [DATA_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              wb_valid,
    output logic [DATA_W-1:0] wb_data
);

    localparam int LANES     = DATA_W / 8;
    localparam int LANE_BITS = $clog2(LANES);

    logic [LANE_BITS-1:0] req_lane;
    logic                 q_valid;
    logic [OP_W-1:0]      q_op;
    logic [LANE_BITS-1:0] q_lane;
    logic [DATA_W-1:0]    q_old;
    logic [DATA_W-1:0]    ext_data;
    logic [DATA_W-1:0]    mrg_data;

    ldu_addr_gen #(
        .ADDR_W    (DATA_W),
        .OFFS_W    (OFFS_W),
        .LANE_BITS (LANE_BITS)
    ) u_addr (
        .base      (req_base),
        .offset    (req_offset),
        .word_addr (mem_addr),
        .lane      (req_lane)
    );

    // Read only for opcodes the unit services.
    always_comb begin
        mem_rd_en = req_valid && op_known(req_op);
    end

    // Capture the request context for the data-return cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_valid <= 1'b0;
            q_op    <= '0;
            q_lane  <= '0;
            q_old   <= '0;
        end else begin
            q_valid <= mem_rd_en;
            if (mem_rd_en) begin
                q_op   <= req_op;
                q_lane <= req_lane;
                q_old  <= req_old;
            end
        end
    end

    ldu_lane_extract #(
        .DATA_W (DATA_W)
    ) u_extract (
        .word   (mem_rdata),
        .lane   (q_lane),
        .op     (q_op),
        .result (ext_data)
    );

    ldu_partial_merge #(
        .DATA_W (DATA_W)
    ) u_merge (
        .word   (mem_rdata),
        .old    (q_old),
        .lane   (q_lane),
        .left   (q_op == LD_LEFT),
        .result (mrg_data)
    );

    // Pick the write-back path by load kind.
    always_comb begin
        wb_valid = q_valid;
        wb_data  = op_partial(q_op) ? mrg_data : ext_data;
    end

    // R2: a read is always followed by a write-back.
    p_read_then_wb_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> wb_valid);

    // R2: no write-back without a read the cycle before.
    p_wb_needs_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> $past(mem_rd_en));

    // R9: unserviced opcodes never reach memory.
    p_unknown_no_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !op_known(req_op)) |-> !mem_rd_en);

    // R6: word and linked loads pass memory data through.
    p_word_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && (q_op == LD_WORD || q_op == LD_LINKED)) |-> wb_data == mem_rdata);

    // R4: unsigned byte leaves upper bits clear.
    p_ubyte_upper_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && q_op == LD_BYTE_U) |-> wb_data[DATA_W-1:8] == '0);

    // R8: right partial at lane 0 keeps the old value.
    p_right_lane0_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && q_op == LD_RIGHT && q_lane == '0) |-> wb_data == q_old);

    // R7: left partial at lane 0 returns the whole word.
    p_left_lane0_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && q_op == LD_LEFT && q_lane == '0) |-> wb_data == mem_rdata);

endmodule

// File: tb/load_align_unit_bench.sv
module load_align_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [5:0]  req_op;
    logic [31:0] req_base;
    logic [15:0] req_offset;
    logic [31:0] req_old;
    logic        mem_rd_en;
    logic [31:0] mem_addr;
    logic [31:0] mem_rdata;
    logic        wb_valid;
    logic [31:0] wb_data;

    int checks   = 0;
    int failures = 0;

    logic [31:0] mem_model [16];
    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #2 clk = ~clk;

    load_align_unit u_load_align_unit (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_op     (req_op),
        .req_base   (req_base),
        .req_offset (req_offset),
        .req_old    (req_old),
        .mem_rd_en  (mem_rd_en),
        .mem_addr   (mem_addr),
        .mem_rdata  (mem_rdata),
        .wb_valid   (wb_valid),
        .wb_data    (wb_data)
    );

    // Synchronous memory model, one-cycle read latency.
    always @(posedge clk) begin
        if (mem_rd_en) mem_rdata <= mem_model[mem_addr[5:2]];
    end

    task automatic check(input logic ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // Expected result from the requirements, by big-endian byte index.
    function automatic logic [31:0] model(input logic [5:0] op, input logic [31:0] ea,
                                          input logic [31:0] old);
        logic [31:0] w;
        logic [7:0]  b [4];
        logic [15:0] h;
        logic [31:0] r;
        int          k;
        w = mem_model[ea[5:2]];
        k = int'(ea[1:0]);
        for (int j = 0; j < 4; j++) b[j] = w[31-8*j -: 8];
        h = ea[1] ? {b[2], b[3]} : {b[0], b[1]};
        r = old;
        case (op)
            6'd32: r = {{24{b[k][7]}}, b[k]};
            6'd36: r = {24'h0, b[k]};
            6'd33: r = {{16{h[15]}}, h};
            6'd37: r = {16'h0, h};
            6'd35, 6'd48: r = w;
            6'd34: for (int j = 0; j < 4; j++)
                       if (j + k < 4) r[31-8*j -: 8] = b[j+k];
            6'd38: for (int j = 0; j < 4; j++)
                       if (j >= 4 - k) r[31-8*j -: 8] = b[j-(4-k)];
            default: r = 'x;
        endcase
        return r;
    endfunction

    // Driver: present one request and push its expected result.
    task automatic do_load(input logic [5:0] op, input logic [31:0] base,
                           input logic [15:0] off, input logic [31:0] old,
                           input string tag);
        logic [31:0] ea;
        ea = base + {{16{off[15]}}, off};
        @(negedge clk);
        req_valid  = 1'b1;
        req_op     = op;
        req_base   = base;
        req_offset = off;
        req_old    = old;
        #1;
        check(mem_rd_en === 1'b1, "R1 read enable", {31'h0, mem_rd_en}, 32'h1);
        check(mem_addr === {ea[31:2], 2'b00}, "R1 address", mem_addr, {ea[31:2], 2'b00});
        exp_q.push_back(model(op, ea, old));
        tag_q.push_back(tag);
    endtask

    // Unserviced opcode: no read, no write-back (R9).
    task automatic do_bad(input logic [5:0] op);
        @(negedge clk);
        req_valid  = 1'b1;
        req_op     = op;
        req_base   = 32'h0000_0010;
        req_offset = 16'h0004;
        #1;
        check(mem_rd_en === 1'b0, "R9 no read", {31'h0, mem_rd_en}, 32'h0);
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        check(wb_valid === 1'b0, "R9 no write-back", {31'h0, wb_valid}, 32'h0);
    endtask

    // Monitor: compare each write-back against the scoreboard head.
    always @(negedge clk) begin
        if (rst_n === 1'b1 && wb_valid === 1'b1) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2 unexpected write-back", wb_data, 32'h0);
            end else begin
                logic [31:0] e;
                string       t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(wb_data === e, t, wb_data, e);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog", 32'h0, 32'h0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++)
            mem_model[i] = (i % 2 == 0) ? {8'h80 | 8'(i), 8'h7F, 8'hC3, 8'h1E}
                                        : {8'h3C, 8'hE1, 8'h55, 8'hAA ^ 8'(i)};
        rst_n      = 1'b0;
        req_valid  = 1'b0;
        req_op     = 6'd0;
        req_base   = '0;
        req_offset = '0;
        req_old    = '0;
        repeat (3) @(negedge clk);
        check(wb_valid === 1'b0, "R10 reset", {31'h0, wb_valid}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(wb_valid === 1'b0, "R10 after reset", {31'h0, wb_valid}, 32'h0);

        // R6 / R1: word and linked loads, negative and positive displacement.
        do_load(6'd35, 32'h0000_0020, 16'hFFF8, 32'h0, "R6 word neg offset");
        do_load(6'd48, 32'h0000_0011, 16'h0003, 32'h0, "R6 linked aligned");
        do_load(6'd35, 32'h0000_0003, 16'h0000, 32'h0, "R6 word unaligned");
        // R3 / R4: every byte lane, signed and unsigned, back-to-back (R2).
        for (int k = 0; k < 4; k++)
            do_load(6'd32, 32'h0000_0008 + 32'(k), 16'h0000, 32'h0, "R4 R3 signed byte");
        for (int k = 0; k < 4; k++)
            do_load(6'd36, 32'h0000_0014 + 32'(k), 16'h0000, 32'h0, "R4 R3 unsigned byte");
        // R5: halfwords at all four offsets, bit 0 ignored.
        for (int k = 0; k < 4; k++)
            do_load(6'd33, 32'h0000_0018 + 32'(k), 16'h0000, 32'h0, "R5 signed half");
        for (int k = 0; k < 4; k++)
            do_load(6'd37, 32'h0000_0004 + 32'(k), 16'h0000, 32'h0, "R5 unsigned half");
        // R7 / R8: partial merges against a contrasting old value.
        for (int k = 0; k < 4; k++)
            do_load(6'd34, 32'h0000_0030 + 32'(k), 16'hFFF0, 32'hA5B6_C7D8, "R7 left partial");
        for (int k = 0; k < 4; k++)
            do_load(6'd38, 32'h0000_0025 + 32'(k), 16'hFFFF, 32'h9182_7364, "R8 right partial");
        @(negedge clk);
        req_valid = 1'b0;
        // R9: opcodes outside the set.
        do_bad(6'd0);
        do_bad(6'd39);
        do_bad(6'd40);
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R2 all results delivered", 32'(exp_q.size()), 32'h0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule